// File: doc/BRIEF.md
# GPIO Bank Edge Interrupt Controller

This block controls one bank of general-purpose pins from a plain 32-bit register bus. For each pin it holds an output value, a direction, a pull-disable flag and an alternate-function select. Software changes the output value and the direction through separate set and clear offsets, so it never has to read, modify and write back a shared word. When a pin is an input with pulls enabled, its output-value bit picks the pull direction. Reading the value offset returns the synchronised level on the pin, not the stored bit.

Pin inputs pass through a two-stage synchroniser. A one-cycle delayed copy of the synchronised level gives rising and falling edges. Each kind of edge has its own per-pin mask. Unmasked edges latch into a sticky status word, software clears that word by writing ones, and a single interrupt line is high while any status bit is set. The asynchronous reset is released through an internal synchroniser.

Top module: `gpio_edge_bank`

## Requirements
- R1: During reset and after it, every stored register reads 0. So every pin is an input (`pin_oe`=0), `pull_dn` is all ones, `pull_up` is 0, `alt_sel` is 0 and `irq` is 0.
- R2: Offset 0x00 loads the output-value word. At 0x04 each 1 bit sets the matching value bit, and at 0x08 each 1 bit clears it. A 0 bit at 0x04 or 0x08 leaves that bit alone.
- R3: At 0x14 each 1 bit makes the pin an output (direction 1), and at 0x18 each 1 bit makes it an input (direction 0). Zero bits change nothing. Offset 0x10 writes and reads the whole direction word.
- R4: For a pin that is an input with its pull-disable bit (offset 0x0C) at 0, `pull_up` equals the value bit and `pull_dn` equals its inverse. If the pin is an output or pull-disable is 1, both pulls are 0.
- R5: A read of 0x00 returns the level of `pin_in`, taken after two synchroniser flops.
- R6: `pin_oe` is direction AND NOT alt-select, and `pin_out` is value AND `pin_oe`. Offset 0x20 holds the alt-select word, and it drives `alt_sel`.
- R7: A rising edge on a pin sets its status bit (read at 0x48) when its bit in the rising mask (0x40) is 1.
- R8: A falling edge sets the status bit when its bit in the falling mask (0x44) is 1. Both masks may be enabled on one pin at the same time.
- R9: An edge whose mask bit is 0 leaves the status bit at 0.
- R10: Each 1 bit written to 0x4C clears the matching status bit, and 0 bits keep their status. Writing all ones clears everything.
- R11: When an enabled edge and a clear for the same bit arrive in the same cycle, the status bit stays set.
- R12: `irq` is 1 exactly when some status bit is 1.
- R13: Reads of 0x04, 0x08, 0x14, 0x18, 0x4C and of any unmapped offset return 0. Read data appears on `bus_rdata` one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 32 | Pin levels from the pads |
| pin_out | output | 32 | Output level to the pads |
| pin_oe | output | 32 | Output enable to the pads |
| pull_up | output | 32 | Pull-up request |
| pull_dn | output | 32 | Pull-down request |
| alt_sel | output | 32 | Alternate-function select |
| irq | output | 1 | Combined edge interrupt |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as a fresh edge on the same bit. The bench first leaves the bit pending. It then drops the pin, counts the two synchroniser edges and the detector delay, and drives the clear so it is sampled in exactly the cycle the falling edge is latched. A design where the clear wins would show a zero status bit there. Each pin is also swept through all four rising/falling mask combinations, in both directions of transition.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned OFS_VAL   = 'h00;
  localparam int unsigned OFS_VSET  = 'h04;
  localparam int unsigned OFS_VCLR  = 'h08;
  localparam int unsigned OFS_PDIS  = 'h0C;
  localparam int unsigned OFS_DIR   = 'h10;
  localparam int unsigned OFS_DSET  = 'h14;
  localparam int unsigned OFS_DCLR  = 'h18;
  localparam int unsigned OFS_ALT   = 'h20;
  localparam int unsigned OFS_RMASK = 'h40;
  localparam int unsigned OFS_FMASK = 'h44;
  localparam int unsigned OFS_STAT  = 'h48;
  localparam int unsigned OFS_SCLR  = 'h4C;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int NPIN   = 32,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] async_in,
  output logic [NPIN-1:0] sync_out
);
  logic [STAGES-1:0][NPIN-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata,
  input  logic [NPIN-1:0]   pin_lvl,
  input  logic [NPIN-1:0]   status,
  output logic [NPIN-1:0]   val_q,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   pdis_q,
  output logic [NPIN-1:0]   alt_q,
  output logic [NPIN-1:0]   rmask_q,
  output logic [NPIN-1:0]   fmask_q,
  output logic [NPIN-1:0]   clr_mask
);
  logic [NPIN-1:0]   w;
  logic [NPIN-1:0]   val_d, dir_d, pdis_d, alt_d, rmask_d, fmask_d;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  assign w = wdata[NPIN-1:0];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    val_d    = val_q;
    dir_d    = dir_q;
    pdis_d   = pdis_q;
    alt_d    = alt_q;
    rmask_d  = rmask_q;
    fmask_d  = fmask_q;
    clr_mask = '0;
    if (wr) begin
      if (hit(addr, OFS_VAL))   val_d   = w;
      if (hit(addr, OFS_VSET))  val_d   = val_q | w;
      if (hit(addr, OFS_VCLR))  val_d   = val_q & ~w;
      if (hit(addr, OFS_PDIS))  pdis_d  = w;
      if (hit(addr, OFS_DIR))   dir_d   = w;
      if (hit(addr, OFS_DSET))  dir_d   = dir_q | w;
      if (hit(addr, OFS_DCLR))  dir_d   = dir_q & ~w;
      if (hit(addr, OFS_ALT))   alt_d   = w;
      if (hit(addr, OFS_RMASK)) rmask_d = w;
      if (hit(addr, OFS_FMASK)) fmask_d = w;
      if (hit(addr, OFS_SCLR))  clr_mask = w;
    end
  end

  always_comb begin
    rdata_d = '0;
    if      (hit(addr, OFS_VAL))   rdata_d = DATA_W'(pin_lvl);
    else if (hit(addr, OFS_PDIS))  rdata_d = DATA_W'(pdis_q);
    else if (hit(addr, OFS_DIR))   rdata_d = DATA_W'(dir_q);
    else if (hit(addr, OFS_ALT))   rdata_d = DATA_W'(alt_q);
    else if (hit(addr, OFS_RMASK)) rdata_d = DATA_W'(rmask_q);
    else if (hit(addr, OFS_FMASK)) rdata_d = DATA_W'(fmask_q);
    else if (hit(addr, OFS_STAT))  rdata_d = DATA_W'(status);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q   <= '0;
      dir_q   <= '0;
      pdis_q  <= '0;
      alt_q   <= '0;
      rmask_q <= '0;
      fmask_q <= '0;
    end else if (wr) begin
      val_q   <= val_d;
      dir_q   <= dir_d;
      pdis_q  <= pdis_d;
      alt_q   <= alt_d;
      rmask_q <= rmask_d;
      fmask_q <= fmask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R2
  vset_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_W'(OFS_VSET)) |=> ((val_q & $past(w)) == $past(w)));
  // R3
  dclr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == ADDR_W'(OFS_DCLR)) |=> ((dir_q & $past(w)) == '0));
  // R3
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_edge_status.sv
module gpio_edge_status #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] lvl,
  input  logic [NPIN-1:0] rise_en,
  input  logic [NPIN-1:0] fall_en,
  input  logic [NPIN-1:0] clr_mask,
  output logic [NPIN-1:0] status_q,
  output logic            irq
);
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] rise, fall, hit;
  logic [NPIN-1:0] status_d;

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
  assign hit  = (rise & rise_en) | (fall & fall_en);

  always_comb begin
    status_d = (status_q & ~clr_mask) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= lvl;
      status_q <= status_d;
    end
  end

  assign irq = |status_q;

  // R11
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lvl & ~prev_q & rise_en) & ~status_q) == '0));
  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(rise_en | fall_en)) == '0));
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~$past(clr_mask)) & ~status_q) == '0));
endmodule

// File: rtl/gpio_pad_map.sv
module gpio_pad_map #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] val,
  input  logic [NPIN-1:0] dir,
  input  logic [NPIN-1:0] pdis,
  input  logic [NPIN-1:0] alt,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic [NPIN-1:0] pull_up,
  output logic [NPIN-1:0] pull_dn
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic drive, pull_on;
    assign drive      = dir[i] & ~alt[i];
    assign pull_on    = ~dir[i] & ~pdis[i];
    assign pin_oe[i]  = drive;
    assign pin_out[i] = drive & val[i];
    assign pull_up[i] = pull_on & val[i];
    assign pull_dn[i] = pull_on & ~val[i];
  end

  // R6
  alt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe | pin_out) & alt) == '0);
  // R4
  pull_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pull_up & pull_dn) == '0) && (((pull_up | pull_dn) & (dir | pdis)) == '0));
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int NPIN        = 32,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_out,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pull_up,
  output logic [NPIN-1:0]   pull_dn,
  output logic [NPIN-1:0]   alt_sel,
  output logic              irq
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [NPIN-1:0] lvl, status, val, dir, pdis, alt, rmask, fmask, clr_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  gpio_pin_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .async_in(pin_in), .sync_out(lvl));

  gpio_bank_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .addr(bus_addr), .wr(bus_wr),
    .wdata(bus_wdata), .rd(bus_rd), .rdata(bus_rdata), .pin_lvl(lvl),
    .status(status), .val_q(val), .dir_q(dir), .pdis_q(pdis), .alt_q(alt),
    .rmask_q(rmask), .fmask_q(fmask), .clr_mask(clr_mask));

  gpio_edge_status #(.NPIN(NPIN)) u_edge (
    .clk(clk), .rst_n(rst_int_n), .lvl(lvl), .rise_en(rmask),
    .fall_en(fmask), .clr_mask(clr_mask), .status_q(status), .irq(irq));

  gpio_pad_map #(.NPIN(NPIN)) u_pad (
    .clk(clk), .rst_n(rst_int_n), .val(val), .dir(dir), .pdis(pdis),
    .alt(alt), .pin_out(pin_out), .pin_oe(pin_oe), .pull_up(pull_up),
    .pull_dn(pull_dn));

  assign alt_sel = alt;

  // R12
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq == (bus_rd && bus_addr == ADDR_W'(gpio_bank_pkg::OFS_STAT) ? irq : (status != '0)));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> (pin_oe == '0 && !irq && alt_sel == '0));
endmodule

// File: tb/sim_gpio_edge_bank.sv
module sim_gpio_edge_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe, pull_up, pull_dn, alt_sel;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_val, m_dir, m_pdis, m_alt, rd_v;

  always #2 clk = ~clk;

  gpio_edge_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pull_up(pull_up),
    .pull_dn(pull_dn), .alt_sel(alt_sel), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  task automatic pads(input string req);
    logic [31:0] pull_on;
    pull_on = ~m_dir & ~m_pdis;
    check(req, pull_up, pull_on & m_val);
    check(req, pull_dn, pull_on & ~m_val);
    check(req, pin_oe, m_dir & ~m_alt);
    check(req, pin_out, m_val & m_dir & ~m_alt);
    check(req, alt_sel, m_alt);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    m_val = '0; m_dir = '0; m_pdis = '0; m_alt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    check("R1", pull_dn, 32'hFFFF_FFFF);
    check("R1", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    pads("R1");
    check("R1", {31'd0, irq}, 32'd0);
    foreach (u0.u_regs.w[k]) begin end
    for (int a = 'h0C; a <= 'h48; a += 4) begin
      rd(8'(a), rd_v);
      check("R1", rd_v, 32'd0);
    end

    // R2 set/clear/load
    wr(8'h04, 32'hF0F0_1234); m_val |= 32'hF0F0_1234; @(negedge clk); pads("R2");
    wr(8'h08, 32'h0000_1200); m_val &= ~32'h0000_1200; @(negedge clk); pads("R2");
    wr(8'h04, 32'h0000_0000); @(negedge clk); pads("R2");
    wr(8'h00, 32'h5A5A_00FF); m_val = 32'h5A5A_00FF; @(negedge clk); pads("R2");
    wr(8'h08, 32'h0);         @(negedge clk); pads("R2");

    // R3 direction
    wr(8'h14, 32'h0000_FFFF); m_dir |= 32'h0000_FFFF;
    rd(8'h10, rd_v); check("R3", rd_v, m_dir); pads("R3");
    wr(8'h18, 32'h0000_0F0F); m_dir &= ~32'h0000_0F0F;
    rd(8'h10, rd_v); check("R3", rd_v, m_dir); pads("R3");
    wr(8'h10, 32'hC000_0003); m_dir = 32'hC000_0003;
    rd(8'h10, rd_v); check("R3", rd_v, m_dir);

    // R4 pulls
    wr(8'h0C, 32'h00FF_0000); m_pdis = 32'h00FF_0000;
    rd(8'h0C, rd_v); check("R4", rd_v, m_pdis); pads("R4");

    // R6 alternate function
    wr(8'h14, 32'hFFFF_FFFF); m_dir = '1;
    wr(8'h20, 32'h3333_0000); m_alt = 32'h3333_0000;
    rd(8'h20, rd_v); check("R6", rd_v, m_alt); pads("R6");
    wr(8'h20, 32'h0); m_alt = '0; @(negedge clk); pads("R6");
    wr(8'h10, 32'h0); m_dir = '0; @(negedge clk); pads("R4");

    // R13 write-only and unmapped offsets
    for (int i = 0; i < 6; i++) begin
      logic [7:0] offs [6] = '{8'h04, 8'h08, 8'h14, 8'h18, 8'h4C, 8'h1C};
      rd(offs[i], rd_v); check("R13", rd_v, 32'd0);
    end

    // R5 live level
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      pin_in = 32'h1357_9BDF * (p + 1) ^ (32'h1 << (p * 4));
      settle();
      rd(8'h00, rd_v); check("R5", rd_v, pin_in);
    end
    @(negedge clk); pin_in = '0; settle();

    // R7 R8 R9 R12 per-pin, per-mask sweep
    for (int i = 0; i < 32; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] b;
        b = 32'h1 << i;
        wr(8'h40, m[0] ? b : 32'h0);
        wr(8'h44, m[1] ? b : 32'h0);
        @(negedge clk); pin_in = b; settle();
        rd(8'h48, rd_v); check(m[0] ? "R7" : "R9", rd_v, m[0] ? b : 32'h0);
        check("R12", {31'd0, irq}, {31'd0, m[0]});
        wr(8'h4C, 32'hFFFF_FFFF);
        @(negedge clk); pin_in = '0; settle();
        rd(8'h48, rd_v); check(m[1] ? "R8" : "R9", rd_v, m[1] ? b : 32'h0);
        check("R12", {31'd0, irq}, {31'd0, m[1]});
        wr(8'h4C, 32'hFFFF_FFFF);
      end
    end

    // R10 partial clear
    wr(8'h40, 32'hFFFF_FFFF);
    @(negedge clk); pin_in = 32'h0000_FFFF; settle();
    rd(8'h48, rd_v); check("R10", rd_v, 32'h0000_FFFF);
    wr(8'h4C, 32'h0000_00FF);
    rd(8'h48, rd_v); check("R10", rd_v, 32'h0000_FF00);
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h48, rd_v); check("R10", rd_v, 32'h0);
    check("R12", {31'd0, irq}, 32'd0);
    @(negedge clk); pin_in = '0; settle();
    wr(8'h4C, 32'hFFFF_FFFF);

    // R11 edge and clear in the same cycle
    wr(8'h40, 32'h20); wr(8'h44, 32'h20);
    @(negedge clk); pin_in = 32'h20; settle();
    rd(8'h48, rd_v); check("R11", rd_v, 32'h20);
    @(negedge clk); pin_in = 32'h0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_addr = 8'h4C; bus_wdata = 32'h20; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_wr = 1'b0;
    rd(8'h48, rd_v); check("R11", rd_v, 32'h20);
    wr(8'h4C, 32'h20);
    rd(8'h48, rd_v); check("R10", rd_v, 32'h0);

    finish_run();
  end
endmodule